// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block timestamps transitions on one external input pin against a free-running counter that lives elsewhere. The pin is first brought into the local clock domain through a two-stage synchronizer. A transition is then classified as rising or falling by comparing the synchronized level with its previous sample. When the transition matches the selected edge mode and the pin is configured as an input, the counter value present on that clock is stored.

There are two capture slots, filled strictly in order: the first accepted edge goes to slot one, the second to slot two. After that the unit is full and ignores all further edges until it is re-armed. Re-arming happens on a capture-status-clear strobe, or when the edge mode changes from "off" to any edge mode. A single-cycle capture event strobe marks either the first or the second capture, as chosen by a select input. The counter and any interrupt status register sit outside the block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read zero and the event strobe is low.
- R2: The 2-bit mode input is encoded as 0 = off, 1 = rising edge, 2 = falling edge, 3 = either edge. Only transitions of the selected kind are accepted; mode 0 accepts none.
- R3: While the direction input is 0 (pin used as output), no edge is captured: both registers hold their values and no event occurs.
- R4: An accepted edge stores `count_val` into the next free slot. The store happens on the third rising clock edge after the pin changes (two synchronizer stages plus the edge-detect compare). The value stored is `count_val` as sampled on that clock. The first accepted edge fills register 1 and the second fills register 2.
- R5: Once both slots are filled, further edges change neither register and raise no event.
- R6: `cap_event` is high for exactly one cycle, in the same cycle as the register update. With `second_sel` = 0 it marks the first capture; with `second_sel` = 1 it marks the second capture.
- R7: A one-cycle pulse on `cap_clr` re-arms the unit, so the next accepted edge goes to register 1. The stored values are not cleared. If a clear coincides with a qualifying edge, the clear wins and that edge is dropped.
- R8: A change of the mode input from 0 to any non-zero value re-arms the unit in the same way as `cap_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous external pin level |
| count_val | input | CNT_W | Live counter value |
| cap_mode | input | 2 | Edge mode: 0 off, 1 rising, 2 falling, 3 both |
| pin_is_input | input | 1 | 1 = pin used as capture input |
| second_sel | input | 1 | 0 = event on first capture, 1 = on second |
| cap_clr | input | 1 | Capture-status clear, re-arms slots |
| cap1_val | output | CNT_W | First capture register |
| cap2_val | output | CNT_W | Second capture register |
| cap_event | output | 1 | One-cycle capture event strobe |

## Verification
The bench sweeps all four edge modes, both pin directions and both event-select settings. For each combination it applies a fixed train of six alternating transitions, each carrying a distinct counter value. The sweep separates rising, falling and double-edge classification, and shows that the third and later edges are dropped once both slots are full. It also shows on which capture the event lands. Every transition is also checked one clock before the expected store, which pins down the synchronizer latency. After each train a clear pulse followed by one more rise/fall pair checks re-arming, and checks that the clear leaves the stored values intact.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_ANY  = 2'd3
  } cap_mode_e;

  localparam int unsigned SLOTS = 2;
  localparam int unsigned IDX_W = $clog2(SLOTS + 1);

endpackage

// File: rtl/ecap_rst_sync.sv
module ecap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ecap_edge_qual.sv
module ecap_edge_qual
  import ecap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  cap_mode_e mode,
  output logic      hit,
  output logic      arm
);

  logic      level_prev_q;
  logic      rise;
  logic      fall;
  cap_mode_e mode_prev_q;

  always_comb begin
    rise = level & ~level_prev_q;
    fall = ~level & level_prev_q;
    unique case (mode)
      CAP_RISE: hit = rise;
      CAP_FALL: hit = fall;
      CAP_ANY:  hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    arm = (mode_prev_q == CAP_OFF) && (mode != CAP_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_prev_q <= 1'b0;
      mode_prev_q  <= CAP_OFF;
    end else begin
      level_prev_q <= level;
      mode_prev_q  <= mode;
    end
  end

endmodule

// File: rtl/ecap_slot_bank.sv
module ecap_slot_bank
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take_req,
  input  logic                      rearm,
  input  logic                      second_sel,
  input  logic [CNT_W-1:0]          count_val,
  output logic [SLOTS-1:0][CNT_W-1:0] slot_val,
  output logic [IDX_W-1:0]          slot_idx,
  output logic                      event_out
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             take;
  logic             event_q, event_d;

  always_comb begin
    idx_d = idx_q;
    take  = 1'b0;
    if (rearm) begin
      idx_d = '0;
    end else if (take_req && (idx_q < IDX_W'(SLOTS))) begin
      take  = 1'b1;
      idx_d = idx_q + 1'b1;
    end
    event_d = take && (idx_q == IDX_W'(second_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      event_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      event_q <= event_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             wr_en;
    logic [CNT_W-1:0] val_q, val_d;

    always_comb begin
      wr_en = take && (idx_q == IDX_W'(g));
      val_d = wr_en ? count_val : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign slot_val[g] = val_q;
  end

  assign slot_idx  = idx_q;
  assign event_out = event_q;

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic [CNT_W-1:0] count_val,
  input  logic [1:0]       cap_mode,
  input  logic             pin_is_input,
  input  logic             second_sel,
  input  logic             cap_clr,
  output logic [CNT_W-1:0] cap1_val,
  output logic [CNT_W-1:0] cap2_val,
  output logic             cap_event
);

  logic                        rst_n_int;
  logic                        pin_sync;
  logic                        edge_hit;
  logic                        arm_pulse;
  logic                        take_req;
  logic                        rearm;
  logic [IDX_W-1:0]            slot_cnt;
  logic [SLOTS-1:0][CNT_W-1:0] slot_val;

  ecap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ecap_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  ecap_edge_qual u_qual (
    .clk   (clk),
    .rst_n (rst_n_int),
    .level (pin_sync),
    .mode  (cap_mode_e'(cap_mode)),
    .hit   (edge_hit),
    .arm   (arm_pulse)
  );

  always_comb begin
    take_req = edge_hit & pin_is_input;
    rearm    = cap_clr | arm_pulse;
  end

  ecap_slot_bank #(.CNT_W(CNT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .take_req   (take_req),
    .rearm      (rearm),
    .second_sel (second_sel),
    .count_val  (count_val),
    .slot_val   (slot_val),
    .slot_idx   (slot_cnt),
    .event_out  (cap_event)
  );

  assign cap1_val = slot_val[0];
  assign cap2_val = slot_val[1];

endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cap_mode,
  input logic             pin_is_input,
  input logic             cap_clr,
  input logic [CNT_W-1:0] cap1_val,
  input logic [CNT_W-1:0] cap2_val,
  input logic             cap_event,
  input logic [IDX_W-1:0] slot_cnt,
  input logic             arm_pulse
);

  // R2: mode off never stores anything
  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'd0) |=> ($stable(cap1_val) && $stable(cap2_val) && !cap_event));

  // R3: pin used as output never stores anything
  a_r3_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input |=> ($stable(cap1_val) && $stable(cap2_val) && !cap_event));

  // R4: slot index never passes the slot count
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= IDX_W'(2));

  // R5: full bank ignores edges unless re-armed
  a_r5_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt == IDX_W'(2) && !cap_clr && !arm_pulse)
      |=> ($stable(cap1_val) && $stable(cap2_val) && !cap_event));

  // R6: event is a single-cycle strobe
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> !cap_event);

  // R7: clear resets the index and drops a coincident edge
  a_r7_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clr |=> (slot_cnt == '0 && !cap_event));

  // R8: arming from off resets the index
  a_r8_arm_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |=> (slot_cnt == '0));

endmodule

bind edge_capture_unit edge_capture_unit_chk #(
  .CNT_W (CNT_W),
  .IDX_W (ecap_pkg::IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_mode     (cap_mode),
  .pin_is_input (pin_is_input),
  .cap_clr      (cap_clr),
  .cap1_val     (cap1_val),
  .cap2_val     (cap2_val),
  .cap_event    (cap_event),
  .slot_cnt     (slot_cnt),
  .arm_pulse    (arm_pulse)
);

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;

  localparam int CNT_W = 32;

  logic             clk;
  logic             rst_n;
  logic             pin_in;
  logic [CNT_W-1:0] count_val;
  logic [1:0]       cap_mode;
  logic             pin_is_input;
  logic             second_sel;
  logic             cap_clr;
  logic [CNT_W-1:0] cap1_val;
  logic [CNT_W-1:0] cap2_val;
  logic             cap_event;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [CNT_W-1:0] m_c1, m_c2;
  int               m_slot;

  edge_capture_unit #(.CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_in       (pin_in),
    .count_val    (count_val),
    .cap_mode     (cap_mode),
    .pin_is_input (pin_is_input),
    .second_sel   (second_sel),
    .cap_clr      (cap_clr),
    .cap1_val     (cap1_val),
    .cap2_val     (cap2_val),
    .cap_event    (cap_event)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [CNT_W-1:0] e1,
                       input logic [CNT_W-1:0] e2, input logic ee);
    checks++;
    if (cap1_val !== e1 || cap2_val !== e2 || cap_event !== ee) begin
      errors++;
      $display("FAIL %s: got c1=%h c2=%h ev=%b, expected c1=%h c2=%h ev=%b",
               tag, cap1_val, cap2_val, cap_event, e1, e2, ee);
    end
  endtask

  function automatic logic qualifies(input int md, input logic lvl);
    case (md)
      1: return lvl;
      2: return !lvl;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one pin transition and check both before and at the store clock.
  task automatic toggle(input logic lvl, input logic [CNT_W-1:0] cnt,
                        input int md, input logic dir, input logic sel,
                        input logic first_after_arm);
    logic  hit;
    logic  ev;
    string tag;
    @(negedge clk);
    pin_in    = lvl;
    count_val = cnt;
    hit = qualifies(md, lvl) && dir && (m_slot < 2);
    ev  = hit && (int'(sel) == m_slot);
    if (!dir)                             tag = "R3 output pin";
    else if (md == 0)                     tag = "R2 mode off";
    else if (qualifies(md, lvl) && m_slot >= 2) tag = "R5 bank full";
    else if (!qualifies(md, lvl))         tag = "R2 edge kind";
    else if (first_after_arm)             tag = "R8 first after arm";
    else                                  tag = "R4 R6 capture";
    // R4: nothing stored yet after two clocks
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({"R4 latency, ", tag}, m_c1, m_c2, 1'b0);
    @(posedge clk);
    @(negedge clk);
    if (hit) begin
      if (m_slot == 0) m_c1 = cnt;
      else             m_c2 = cnt;
      m_slot++;
    end
    check(tag, m_c1, m_c2, ev);
  endtask

  initial begin
    rst_n        = 1'b0;
    pin_in       = 1'b0;
    count_val    = '0;
    cap_mode     = 2'd0;
    pin_is_input = 1'b0;
    second_sel   = 1'b0;
    cap_clr      = 1'b0;
    m_c1 = '0; m_c2 = '0; m_slot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", '0, '0, 1'b0);

    for (int c = 0; c < 16; c++) begin
      int   md;
      logic dir, sel;
      logic seen_hit;
      md  = c & 3;
      dir = c[2];
      sel = c[3];
      @(negedge clk);
      cap_mode     = 2'd0;
      pin_is_input = dir;
      second_sel   = sel;
      repeat (2) @(posedge clk);
      @(negedge clk);
      cap_mode = md[1:0];            // R8: off -> edge mode re-arms
      if (md != 0) m_slot = 0;
      seen_hit = 1'b0;
      for (int t = 0; t < 6; t++) begin
        logic lvl;
        lvl = (t % 2 == 0);
        toggle(lvl, {8'(c), 8'h5A, 8'(t), 8'hC3}, md, dir, sel,
               !seen_hit && qualifies(md, lvl));
        if (qualifies(md, lvl)) seen_hit = 1'b1;
      end
      // R7: clear re-arms, keeps stored values
      @(negedge clk);
      cap_clr = 1'b1;
      @(negedge clk);
      cap_clr = 1'b0;
      m_slot = 0;
      check("R7 clear keeps values", m_c1, m_c2, 1'b0);
      toggle(1'b1, {8'(c), 8'hE7, 8'h10, 8'h3C}, md, dir, sel, 1'b0);
      toggle(1'b0, {8'(c), 8'hE7, 8'h11, 8'h3C}, md, dir, sel, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule